// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block divides each frame of one or two time-division-multiplexed serial lines into a sequence of time slots. For each slot it steers the serial bits to one of several serial controller ports. A routing table in local memory describes every slot: the destination port, the slot length, whether that length counts bits or bytes, a mask of up to four active-high strobe pins, and a flag that closes the frame. Each channel has its own receive table and its own transmit table. The two tables of a channel advance together on that channel's bit-clock ticks.

A host loads the routing memory through a simple write port. Two inputs choose how the memory is split: the number of active channels, and static or dynamic routing. In dynamic mode each table has an active copy and a shadow copy. A host swap request exchanges the two copies at the next frame sync of that channel, and a status output shows which copy is in use. The serial controllers and any pin multiplexing lie outside this block.

Top module: `tsa_router`

## Requirements
- R1: After reset no port strobe is high, every `txd` bit is 1, every strobe pin is 0 and every `bank_active` bit is 0.
- R2: An entry holds port select in bits [2:0], length-minus-one in bits [6:3], a byte flag in bit 7, a strobe mask in bits [11:8] and a last flag in bit 12. On a bit tick with `fsync` high, the channel restarts at the first entry of its table. Starting with the next tick, the channel walks the entries in order. Each entry lasts (length-minus-one + 1) bits, or eight times that when the byte flag is 1.
- R3: While a receive or transmit slot is active, that entry's mask drives the channel's four strobe pins (`strobe[4*ch +: 4]`, active high). The receive mask and the transmit mask are ORed.
- R4: During a receive slot for port p, `port_rx_stb[p]` is 1 and `port_rx_bit[p]` equals the channel's `rxd`. With a single channel, at most one receive strobe is high.
- R5: During a transmit slot for port p, `port_tx_stb[p]` is 1 and the channel's `txd` equals `port_tx_bit[p]`.
- R6: After the slot that carries the last flag, a table strobes no port and leaves `txd` at 1 until the next frame-sync tick. A frame sync during a frame restarts the table at its first entry.
- R7: Address bit 6 selects the receive half (0) or the transmit half (1). Inside each half, the region is set by the mode inputs. With one channel in static mode, the region is all 64 entries. With two channels, channel 1 starts at entry 32 and each region holds 32 entries. Dynamic mode halves the region again, and bank 1 lies directly above bank 0.
- R8: A `swap_req` pulse toggles `bank_active` of its channel on the next frame-sync tick of that channel, and at no other time. When the request coincides with that tick, the toggle happens on that tick. In dynamic mode the frame that starts with that tick reads the newly selected bank.
- R9: While `ch_en[ch]` is 0, the channel ignores frame syncs, strobes nothing and holds `txd` at 1.
- R10: A port whose `port_conn` bit is 0 is never strobed. Its slots still take their full length. A transmit slot to such a port holds `txd` at 1, and its strobe mask still drives the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | N_CH | Per-channel run enable |
| dual_ch | input | 1 | Two-channel partitioning |
| dyn_mode | input | 1 | Dynamic (shadow bank) routing |
| port_conn | input | N_PORT | Per-port connect to the slot router |
| bclk_en | input | N_CH | One-cycle bit tick per channel |
| fsync | input | N_CH | Frame sync, sampled on a bit tick |
| rxd | input | N_CH | Serial receive data per channel |
| txd | output | N_CH | Serial transmit data per channel |
| port_rx_stb | output | N_PORT | Receive slot strobe per port |
| port_rx_bit | output | N_PORT | Receive data routed to each port |
| port_tx_stb | output | N_PORT | Transmit slot strobe per port |
| port_tx_bit | input | N_PORT | Transmit data from each port |
| strobe | output | 4*N_CH | Slot strobe pins, four per channel |
| wr_en | input | 1 | Routing memory write enable |
| wr_addr | input | 7 | Routing memory write address |
| wr_data | input | 32 | Routing memory write data |
| swap_req | input | N_CH | Request bank exchange (dynamic mode) |
| bank_active | output | N_CH | Bank currently in use per channel |

## Verification
Every slot output shows the state that the bit tick in the current cycle consumes. The first entry of a frame appears in the cycle after the frame-sync tick's rising edge, and a change of slot appears in the cycle after the tick that ends the previous slot. The bench raises each tick two nanoseconds after a rising edge and pushes the expected item for that bit. The monitor compares on the falling edge of the same cycle, before the edge that consumes the tick. The bench model advances only after that edge. The bank status is checked in the same per-bit item, so a toggle must appear exactly one tick after the frame sync that takes the request.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   // One slot descriptor in the low bits of a routing word.
   typedef struct packed {
      logic       last;
      logic [3:0] mask;
      logic       unit_byte;
      logic [3:0] len_m1;
      logic [2:0] port;
   } slot_t;

   localparam int SLOT_W  = $bits(slot_t);
   localparam int STB_PER = 4;
   localparam int LEN_W   = 7;
endpackage

// File: rtl/tsa_route_mem.sv
module tsa_route_mem #(
   parameter int DEPTH = 128,
   parameter int W     = 32,
   parameter int NRD   = 4,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [W-1:0]     wr_data,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD*W-1:0]  rd_data
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data[r*W +: W] = mem[rd_addr[r*AW +: AW]];
   end
endmodule

// File: rtl/tsa_bank_ctl.sv
module tsa_bank_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_evt,
   input  logic swap_req,
   output logic bank
);
   logic pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank    <= 1'b0;
         pending <= 1'b0;
      end else if (sync_evt) begin
         bank    <= bank ^ (pending | swap_req);
         pending <= 1'b0;
      end else if (swap_req) begin
         pending <= 1'b1;
      end
   end
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq #(
   parameter int IDX_W = 6,
   parameter int CH    = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                tick,
   input  logic                fsync,
   input  logic                dual,
   input  logic                dyn,
   input  logic                bank,
   input  tsa_pkg::slot_t      ent,
   output logic                run,
   output logic [IDX_W-1:0]    addr
);
   import tsa_pkg::*;
   localparam int HALF = 1 << IDX_W;

   logic [IDX_W-1:0] idx, base, lim;
   logic [LEN_W-1:0] bcnt;
   logic             slot_end, tbl_end;
   int               rsize, base_i;

   always_comb begin
      rsize  = HALF >> (int'(dual) + int'(dyn));
      base_i = 0;
      if (dual) base_i = CH * (HALF / 2);
      if (dyn && bank) base_i = base_i + rsize;
      base = IDX_W'(base_i);
      lim  = IDX_W'(rsize - 1);
   end

   assign addr     = base + idx;
   assign slot_end = ent.unit_byte ? (bcnt == {ent.len_m1, 3'b111})
                                   : (bcnt == {3'b000, ent.len_m1});
   assign tbl_end  = ent.last || (idx == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         run  <= 1'b0;
         idx  <= '0;
         bcnt <= '0;
      end else if (tick) begin
         if (fsync) begin
            run  <= 1'b1;
            idx  <= '0;
            bcnt <= '0;
         end else if (run) begin
            if (slot_end) begin
               bcnt <= '0;
               if (tbl_end) begin
                  run <= 1'b0;
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tsa_router.sv
module tsa_router #(
   parameter int N_CH        = 2,
   parameter int N_PORT      = 5,
   parameter int MEM_ENTRIES = 128,
   parameter int ENTRY_W     = 32,
   localparam int ADDR_W     = $clog2(MEM_ENTRIES),
   localparam int IDX_W      = ADDR_W - 1,
   localparam int NSTB       = tsa_pkg::STB_PER * N_CH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_CH-1:0]     ch_en,
   input  logic                dual_ch,
   input  logic                dyn_mode,
   input  logic [N_PORT-1:0]   port_conn,
   input  logic [N_CH-1:0]     bclk_en,
   input  logic [N_CH-1:0]     fsync,
   input  logic [N_CH-1:0]     rxd,
   output logic [N_CH-1:0]     txd,
   output logic [N_PORT-1:0]   port_rx_stb,
   output logic [N_PORT-1:0]   port_rx_bit,
   output logic [N_PORT-1:0]   port_tx_stb,
   input  logic [N_PORT-1:0]   port_tx_bit,
   output logic [NSTB-1:0]     strobe,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [ENTRY_W-1:0]  wr_data,
   input  logic [N_CH-1:0]     swap_req,
   output logic [N_CH-1:0]     bank_active
);
   import tsa_pkg::*;
   localparam int NRD = 2 * N_CH;

   if (N_CH < 1 || N_CH > 2) begin : g_bad_ch
      $error("tsa_router: N_CH must be 1 or 2");
   end
   if (N_PORT < 1 || N_PORT > 8) begin : g_bad_port
      $error("tsa_router: N_PORT must be 1..8");
   end
   if (MEM_ENTRIES < 16 || (1 << ADDR_W) != MEM_ENTRIES) begin : g_bad_depth
      $error("tsa_router: MEM_ENTRIES must be a power of two >= 16");
   end
   if (ENTRY_W < SLOT_W) begin : g_bad_w
      $error("tsa_router: ENTRY_W too narrow for a slot descriptor");
   end

   logic                 dual_eff;
   logic [NRD*ADDR_W-1:0] rd_addr;
   logic [NRD*ENTRY_W-1:0] rd_data;
   slot_t                rx_ent [N_CH];
   slot_t                tx_ent [N_CH];
   logic [N_CH-1:0]      rx_run, tx_run;

   assign dual_eff = (N_CH == 2) ? dual_ch : 1'b0;

   tsa_route_mem #(.DEPTH(MEM_ENTRIES), .W(ENTRY_W), .NRD(NRD)) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [IDX_W-1:0] rx_idx, tx_idx;
      logic             tick;
      assign tick = bclk_en[c] & ch_en[c];

      tsa_bank_ctl u_bank (
         .clk(clk), .rst_n(rst_n), .sync_evt(tick & fsync[c]),
         .swap_req(swap_req[c]), .bank(bank_active[c])
      );

      tsa_seq #(.IDX_W(IDX_W), .CH(c)) u_rx (
         .clk(clk), .rst_n(rst_n), .en(ch_en[c]), .tick(bclk_en[c]),
         .fsync(fsync[c]), .dual(dual_eff), .dyn(dyn_mode),
         .bank(bank_active[c]), .ent(rx_ent[c]), .run(rx_run[c]), .addr(rx_idx)
      );

      tsa_seq #(.IDX_W(IDX_W), .CH(c)) u_tx (
         .clk(clk), .rst_n(rst_n), .en(ch_en[c]), .tick(bclk_en[c]),
         .fsync(fsync[c]), .dual(dual_eff), .dyn(dyn_mode),
         .bank(bank_active[c]), .ent(tx_ent[c]), .run(tx_run[c]), .addr(tx_idx)
      );

      assign rd_addr[(2*c)*ADDR_W +: ADDR_W]   = {1'b0, rx_idx};
      assign rd_addr[(2*c+1)*ADDR_W +: ADDR_W] = {1'b1, tx_idx};
      assign rx_ent[c] = slot_t'(rd_data[(2*c)*ENTRY_W +: SLOT_W]);
      assign tx_ent[c] = slot_t'(rd_data[(2*c+1)*ENTRY_W +: SLOT_W]);
   end

   always_comb begin
      port_rx_stb = '0;
      port_rx_bit = '0;
      port_tx_stb = '0;
      txd         = '1;
      strobe      = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (rx_run[c]) begin
            strobe[c*STB_PER +: STB_PER] = strobe[c*STB_PER +: STB_PER] | rx_ent[c].mask;
            for (int p = 0; p < N_PORT; p++) begin
               if (rx_ent[c].port == 3'(p) && port_conn[p]) begin
                  port_rx_stb[p] = 1'b1;
                  port_rx_bit[p] = port_rx_bit[p] | rxd[c];
               end
            end
         end
         if (tx_run[c]) begin
            strobe[c*STB_PER +: STB_PER] = strobe[c*STB_PER +: STB_PER] | tx_ent[c].mask;
            for (int p = 0; p < N_PORT; p++) begin
               if (tx_ent[c].port == 3'(p) && port_conn[p]) begin
                  port_tx_stb[p] = 1'b1;
                  txd[c]         = port_tx_bit[p];
               end
            end
         end
      end
   end
endmodule

// File: rtl/tsa_router_chk.sv
module tsa_router_chk #(
   parameter int N_CH   = 2,
   parameter int N_PORT = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_CH-1:0]      ch_en,
   input logic                 dual_ch,
   input logic [N_CH-1:0]      bclk_en,
   input logic [N_CH-1:0]      fsync,
   input logic [N_CH-1:0]      swap_req,
   input logic [N_CH-1:0]      bank_active,
   input logic [N_CH-1:0]      txd,
   input logic [4*N_CH-1:0]    strobe,
   input logic [N_PORT-1:0]    port_rx_stb,
   input logic [N_PORT-1:0]    port_tx_stb,
   input logic [N_PORT-1:0]    port_conn
);
   for (genvar c = 0; c < N_CH; c++) begin : g_c
      assert_idle_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[c] |=> (txd[c] && strobe[4*c +: 4] == 4'b0000));

      assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !(fsync[c] && bclk_en[c] && ch_en[c]) |=> $stable(bank_active[c]));

      assert_bank_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (fsync[c] && bclk_en[c] && ch_en[c] && swap_req[c])
         |=> bank_active[c] != $past(bank_active[c]));
   end

   for (genvar p = 0; p < N_PORT; p++) begin : g_p
      assert_conn_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (port_rx_stb[p] || port_tx_stb[p]) |-> port_conn[p]);
   end

   assert_single_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_ch |-> $onehot0(port_rx_stb));
endmodule

bind tsa_router tsa_router_chk #(.N_CH(N_CH), .N_PORT(N_PORT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .dual_ch(dual_ch),
   .bclk_en(bclk_en), .fsync(fsync), .swap_req(swap_req),
   .bank_active(bank_active), .txd(txd), .strobe(strobe),
   .port_rx_stb(port_rx_stb), .port_tx_stb(port_tx_stb), .port_conn(port_conn)
);

// File: tb/tsa_router_test.sv
module tsa_router_test;
   localparam int NC = 2;
   localparam int NP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [NC-1:0] ch_en = '0, bclk_en = '0, fsync = '0, rxd = '0, swap_req = '0;
   logic          dual_ch = 1'b0, dyn_mode = 1'b0;
   logic [NP-1:0] port_conn = '1;
   logic [NP-1:0] port_tx_bit = 5'b10110;
   logic          wr_en = 1'b0;
   logic [6:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [NC-1:0] txd, bank_active;
   logic [NP-1:0] port_rx_stb, port_rx_bit, port_tx_stb;
   logic [4*NC-1:0] strobe;

   tsa_router uut (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .dual_ch(dual_ch), .dyn_mode(dyn_mode),
      .port_conn(port_conn), .bclk_en(bclk_en), .fsync(fsync), .rxd(rxd), .txd(txd),
      .port_rx_stb(port_rx_stb), .port_rx_bit(port_rx_bit), .port_tx_stb(port_tx_stb),
      .port_tx_bit(port_tx_bit), .strobe(strobe), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .swap_req(swap_req), .bank_active(bank_active)
   );

   int n_run = 0, n_fail = 0;

   typedef struct {
      logic [NP-1:0] rs, ts, rb;
      logic [NC-1:0] td, bk;
      logic [4*NC-1:0] pn;
      string tag;
   } exp_t;
   exp_t q[$];

   // model state: [ch][bank][dir][entry]
   int m_port [2][2][2][8];
   int m_len  [2][2][2][8];
   int m_mask [2][2][2][8];
   int m_last [2][2][2][8];
   int pos [2];
   bit mbank [2];
   bit mpend [2];
   logic [7:0] lf = 8'h5a;

   task automatic check(bit ok, string tag, string msg);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   task automatic clr_model();
      for (int c = 0; c < 2; c++) for (int b = 0; b < 2; b++)
         for (int d = 0; d < 2; d++) for (int e = 0; e < 8; e++) begin
            m_port[c][b][d][e] = 0; m_len[c][b][d][e] = 0;
            m_mask[c][b][d][e] = 0; m_last[c][b][d][e] = 0;
         end
   endtask

   task automatic set_en(logic [NC-1:0] v);
      ch_en = v;
      for (int c = 0; c < NC; c++) if (!v[c]) pos[c] = -1;
   endtask

   task automatic put(int ch, int bk, int dir, int e, int port, int lm1, bit byt, int mask, bit last);
      int size, base;
      size = 64 >> (int'(dual_ch) + int'(dyn_mode));
      base = (dual_ch ? ch * 32 : 0) + ((dyn_mode && bk != 0) ? size : 0);
      @(posedge clk); #2;
      wr_en   = 1'b1;
      wr_addr = 7'(dir * 64 + base + e);
      wr_data = {19'b0, last, 4'(mask), byt, 4'(lm1), 3'(port)};
      @(posedge clk); #2;
      wr_en = 1'b0;
      m_port[ch][bk][dir][e] = port;
      m_len[ch][bk][dir][e]  = (lm1 + 1) * (byt ? 8 : 1);
      m_mask[ch][bk][dir][e] = mask;
      m_last[ch][bk][dir][e] = last;
   endtask

   function automatic void slot_at(int ch, int bk, int dir, int k,
                                   output int port, output int mask, output bit ok);
      int acc = 0;
      ok = 0; port = 0; mask = 0;
      for (int e = 0; e < 8; e++) begin
         if (m_len[ch][bk][dir][e] == 0) break;
         if (k < acc + m_len[ch][bk][dir][e]) begin
            port = m_port[ch][bk][dir][e];
            mask = m_mask[ch][bk][dir][e];
            ok = 1;
            return;
         end
         acc += m_len[ch][bk][dir][e];
         if (m_last[ch][bk][dir][e] != 0) break;
      end
   endfunction

   // driver: one bit tick per call; pushes the expected outputs for that bit
   task automatic step(bit fs0, bit fs1, bit sw0, bit sw1, string tag);
      exp_t e;
      int p, m, bk;
      bit ok, fs, sw;
      @(posedge clk); #2;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      rxd      = {lf[3], lf[0]};
      fsync    = {fs1, fs0};
      swap_req = {sw1, sw0};
      bclk_en  = '1;
      e.rs = '0; e.ts = '0; e.rb = '0; e.td = '1; e.pn = '0;
      e.bk = {mbank[1], mbank[0]};
      e.tag = tag;
      for (int c = 0; c < NC; c++) begin
         if (pos[c] >= 0) begin
            bk = dyn_mode ? int'(mbank[c]) : 0;
            slot_at(c, bk, 0, pos[c], p, m, ok);
            if (ok) begin
               e.pn[4*c +: 4] = e.pn[4*c +: 4] | 4'(m);
               if (p < NP && port_conn[p]) begin
                  e.rs[p] = 1'b1;
                  e.rb[p] = e.rb[p] | rxd[c];
               end
            end
            slot_at(c, bk, 1, pos[c], p, m, ok);
            if (ok) begin
               e.pn[4*c +: 4] = e.pn[4*c +: 4] | 4'(m);
               if (p < NP && port_conn[p]) begin
                  e.ts[p] = 1'b1;
                  e.td[c] = port_tx_bit[p];
               end
            end
         end
      end
      q.push_back(e);
      @(posedge clk); #2;
      bclk_en = '0; fsync = '0; swap_req = '0;
      for (int c = 0; c < NC; c++) begin
         fs = (c == 0) ? fs0 : fs1;
         sw = (c == 0) ? sw0 : sw1;
         if (!ch_en[c]) begin
            pos[c] = -1;
            if (sw) mpend[c] = 1;
         end else if (fs) begin
            mbank[c] = mbank[c] ^ (mpend[c] | sw);
            mpend[c] = 0;
            pos[c] = 0;
         end else begin
            if (sw) mpend[c] = 1;
            if (pos[c] >= 0) pos[c]++;
         end
      end
   endtask

   // monitor: compares each tick's outputs at the falling edge
   always @(negedge clk) begin
      if (rst_n && bclk_en[0] && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(port_rx_stb === e.rs && port_tx_stb === e.ts && txd === e.td &&
               strobe === e.pn && (port_rx_bit & e.rs) === e.rb && bank_active === e.bk,
               e.tag,
               $sformatf("rx_stb=%b tx_stb=%b txd=%b pins=%b rxbit=%b bank=%b expected %b %b %b %b %b %b",
                         port_rx_stb, port_tx_stb, txd, strobe, port_rx_bit & e.rs, bank_active,
                         e.rs, e.ts, e.td, e.pn, e.rb, e.bk));
      end
   end

   initial begin
      #2_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      pos[0] = -1; pos[1] = -1;
      mbank[0] = 0; mbank[1] = 0; mpend[0] = 0; mpend[1] = 0;
      clr_model();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(txd === '1, "R1", $sformatf("txd=%b expected 11", txd));
      check(port_rx_stb === '0 && port_tx_stb === '0, "R1",
            $sformatf("stb=%b/%b expected 0/0", port_rx_stb, port_tx_stb));
      check(strobe === '0, "R1", $sformatf("pins=%b expected 0", strobe));
      check(bank_active === '0, "R1", $sformatf("bank=%b expected 00", bank_active));

      // single channel, static: R2 R3 R4 R5 R6
      put(0, 0, 0, 0, 1, 1, 0, 1, 0);
      put(0, 0, 0, 1, 2, 0, 1, 2, 0);
      put(0, 0, 0, 2, 0, 0, 0, 0, 1);
      put(0, 0, 1, 0, 3, 2, 0, 4, 0);
      put(0, 0, 1, 1, 4, 1, 0, 8, 1);
      set_en(2'b01);
      step(0, 0, 0, 0, "R6");
      step(0, 0, 0, 0, "R6");
      step(1, 0, 0, 0, "R2");
      for (int i = 0; i < 14; i++) step(0, 0, 0, 0, "R2 R3 R4 R5 R6");
      step(1, 0, 0, 0, "R6");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R6");
      step(1, 0, 0, 0, "R6");
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, "R3 R5 R6");

      // unconnected ports: R10
      port_conn = 5'b10011;
      step(1, 0, 0, 0, "R10");
      for (int i = 0; i < 12; i++) step(0, 0, 0, 0, "R10");
      port_conn = '1;

      // channel disabled: R9
      set_en(2'b00);
      step(1, 0, 0, 0, "R9");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R9");

      // two channels, static: R7
      dual_ch = 1'b1;
      clr_model();
      put(0, 0, 0, 0, 0, 3, 0, 1, 1);
      put(0, 0, 1, 0, 1, 3, 0, 2, 1);
      put(1, 0, 0, 0, 2, 1, 0, 3, 0);
      put(1, 0, 0, 1, 3, 0, 1, 4, 1);
      put(1, 0, 1, 0, 4, 5, 0, 8, 1);
      set_en(2'b11);
      step(1, 0, 0, 0, "R7");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R7");
      step(0, 1, 0, 0, "R7");
      for (int i = 0; i < 12; i++) step(0, 0, 0, 0, "R7");

      // one channel, dynamic: R8
      set_en(2'b00);
      dual_ch = 1'b0; dyn_mode = 1'b1;
      clr_model();
      put(0, 0, 0, 0, 0, 2, 0, 1, 1);
      put(0, 0, 1, 0, 1, 2, 0, 2, 1);
      put(0, 1, 0, 0, 4, 1, 0, 2, 0);
      put(0, 1, 0, 1, 3, 0, 0, 4, 1);
      put(0, 1, 1, 0, 2, 2, 0, 4, 1);
      set_en(2'b01);
      step(1, 0, 0, 0, "R8");
      step(0, 0, 0, 0, "R8");
      step(0, 0, 1, 0, "R8");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R8");
      step(1, 0, 0, 0, "R8");
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R8");
      check(bank_active[0] === 1'b1, "R8", $sformatf("bank0=%b expected 1", bank_active[0]));

      // two channels, dynamic (quartered regions): R7 R8
      set_en(2'b00);
      dual_ch = 1'b1;
      clr_model();
      put(1, 0, 0, 0, 0, 1, 0, 1, 1);
      put(1, 0, 1, 0, 2, 0, 0, 2, 1);
      put(1, 1, 0, 0, 1, 1, 0, 4, 1);
      put(1, 1, 1, 0, 3, 0, 0, 8, 1);
      set_en(2'b10);
      step(0, 1, 0, 1, "R7 R8");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R7 R8");
      step(0, 1, 0, 0, "R7");
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R7");

      repeat (3) @(posedge clk);
      check(q.size() == 0, "R2", $sformatf("pending items=%0d expected 0", q.size()));
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule